// File: doc/BRIEF.md
# Asynchronous Memory Bus Front End

This block sits between the pins of an asynchronous parallel memory bus and the synchronous logic of a non-volatile memory. It samples the active-low chip enable, output enable and write enable strobes in a fast system clock, filters out short glitches, and sorts every moment of the bus into one of four cycle kinds: standby, read, write or output disable. From the cycle kind it derives the drive enables for the lower and upper halves of the tri-state data bus.

For every valid write the block emits a single-cycle pulse carrying the captured address, the captured data and the bus organisation in force. The address is taken when the later of the two write strobes falls. The data is taken when the earlier of them rises. The address and data buses pass through a delay line that matches the strobe path, so the captured values are those present on the pins at the strobe edges.

In 8-bit organisation the top data pin acts as the lowest address bit. The block also flags automatic standby once the bus has stayed still for a set time. The glitch width and the idle time are given in picoseconds and turned into clock counts from the clock period parameter.

Top module: `mbfe_top`

## Requirements
- R1: `cyc_kind` reports 0 for standby (CE high), 1 for read (CE low, OE low, WE high), 2 for write (CE low, WE low, OE high) and 3 for output disable (CE low with OE and WE both high, or both low).
- R2: While CE is high, OE and WE have no effect: the kind is standby, both drive enables are low and no write is reported.
- R3: With OE high both drive enables are low. In a read cycle `dq_oe_lo` is high, and `dq_oe_hi` is high in 16-bit organisation.
- R4: The write address, and in 8-bit organisation the lowest address bit, are the pin values present when the later of CE and WE falls. A change after that edge is not reported.
- R5: The write data are the pin values present when the earlier of CE and WE rises, whichever strobe rises first.
- R6: A low pulse on CE, WE or OE that is seen in fewer than GLITCH_CYC clock samples (2 by default) is rejected and starts no cycle. A WE low held for GLITCH_CYC samples with CE low gives a valid write.
- R7: With `x8_n` low, `dq_in[15]` is the lowest address bit: `wr_lsb` carries it, `wr_data[15:8]` is zero, `wr_x8` is 1 and `dq_oe_hi` stays low during reads. With `x8_n` high, `wr_lsb` is 0 and `wr_x8` is 0.
- R8: `auto_stby` rises after IDLE_CYC clocks (75 by default) with no change of the filtered strobes or the address. It falls on the next change. The drive enables of a read that is in progress are not affected by it.
- R9: A write during which OE is low at any point is not reported.
- R10: Each valid write gives exactly one `wr_pulse` lasting one clock, with `wr_addr`, `wr_lsb`, `wr_data` and `wr_x8` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| x8_n | input | 1 | Low selects 8-bit organisation |
| addr_in | input | ADDR_W | Address pins (word address) |
| dq_in | input | DATA_W | Data pins as seen at the pads |
| cyc_kind | output | 2 | Current bus cycle kind (R1 encoding) |
| dq_oe_lo | output | 1 | Drive enable for data bits 7..0 |
| dq_oe_hi | output | 1 | Drive enable for data bits 15..8 |
| wr_pulse | output | 1 | One-cycle write report |
| wr_addr | output | ADDR_W | Captured word address |
| wr_lsb | output | 1 | Byte select bit captured in 8-bit organisation |
| wr_data | output | DATA_W | Captured write data |
| wr_x8 | output | 1 | Organisation in force for this write |
| auto_stby | output | 1 | Automatic standby flag |

## Verification
Writes are driven in all four strobe orderings: CE or WE falls first, combined with CE or WE rises first. The address and data pins change just after the capture edges, so a design that captures at the wrong edge reports junk. Single-sample pulses on CE and WE are compared with a write whose WE low lasts exactly the minimum number of samples, which places the filter threshold between one and two clocks. Byte-mode writes with the select bit at 0 and at 1 show whether the top data pin is treated as an address bit. Writes spoiled by OE, activity while CE is high, and long quiet and long reading intervals separate the ignore, standby and idle rules from each other.

// File: rtl/mbfe_pkg.sv
// Shared types for the asynchronous memory bus front end.
package mbfe_pkg;
    typedef enum logic [1:0] {
        CYC_STANDBY = 2'd0,
        CYC_READ    = 2'd1,
        CYC_WRITE   = 2'd2,
        CYC_ODIS    = 2'd3
    } cyc_kind_t;
endpackage

// File: rtl/mbfe_deglitch.sv
// Synchroniser and glitch filter for one active-low strobe pin.
// The output follows the synchronised pin only after the pin has shown the
// new level for HOLD_CYC consecutive samples. Total latency from pin to
// level is SYNC_STAGES + HOLD_CYC clocks. Assumes an idle-high pin.
module mbfe_deglitch #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYC    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic level
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    logic [SYNC_STAGES-1:0] sync;
    logic [CW-1:0]          cnt;
    logic                   s;

    assign s = sync[SYNC_STAGES-1];

    // Shift the raw pin through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= '1;
        else        sync <= {sync[SYNC_STAGES-2:0], pin_in};
    end

    // Count consecutive differing samples and accept the new level at HOLD_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= 1'b1;
            cnt   <= '0;
        end else if (s == level) begin
            cnt <= '0;
        end else if (cnt == CW'(HOLD_CYC - 1)) begin
            level <= s;
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6
    level_follows_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> ($past(s) == level));
endmodule

// File: rtl/mbfe_delay.sv
// Fixed-depth register delay line used to align the address and data buses
// with the strobe path. Assumes DEPTH >= 1.
module mbfe_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [DEPTH];

    // Shift the bus one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/mbfe_wrcap.sv
// Write capture. Works on filtered strobes and bus values aligned to them.
// The write window is CE low and WE low. The address is taken when the window
// opens, which is the later falling edge. The data are taken when it closes,
// which is the earlier rising edge, and a one-cycle report follows unless OE
// was low anywhere inside the window.
module mbfe_wrcap #(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_f,
    input  logic              oe_f,
    input  logic              we_f,
    input  logic              byte_d,
    input  logic [ADDR_W-1:0] addr_d,
    input  logic [DATA_W-1:0] dq_d,
    output logic              wr_pulse,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_lsb,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_x8
);
    localparam int LO_W = DATA_W / 2;

    logic sel, sel_q, oe_bad;

    assign sel = ~ce_f & ~we_f;

    // Edge tracking of the write window and capture of the address, data and report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= 1'b0;
            oe_bad   <= 1'b0;
            wr_pulse <= 1'b0;
            wr_addr  <= '0;
            wr_lsb   <= 1'b0;
            wr_data  <= '0;
            wr_x8    <= 1'b0;
        end else begin
            sel_q    <= sel;
            wr_pulse <= 1'b0;
            if (sel && !sel_q) begin
                wr_addr <= addr_d;
                wr_lsb  <= byte_d & dq_d[DATA_W-1];
                wr_x8   <= byte_d;
                oe_bad  <= ~oe_f;
            end else if (sel && sel_q) begin
                oe_bad  <= oe_bad | ~oe_f;
            end else if (!sel && sel_q) begin
                wr_pulse <= ~oe_bad;
                wr_data  <= wr_x8 ? {{(DATA_W-LO_W){1'b0}}, dq_d[LO_W-1:0]} : dq_d;
            end
        end
    end

    // R10
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    // R9
    oe_held_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> $past(oe_f, 2));
endmodule

// File: rtl/mbfe_idle.sv
// Idle timer. Counts clocks since the last bus activity and raises the
// standby flag once IDLE_CYC quiet clocks have passed. Activity clears it.
module mbfe_idle #(
    parameter int IDLE_CYC = 75
) (
    input  logic clk,
    input  logic rst_n,
    input  logic activity,
    output logic auto_stby
);
    localparam int CW = $clog2(IDLE_CYC + 1);

    logic [CW-1:0] cnt;

    // Restart on activity, otherwise count up to the idle limit and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            auto_stby <= 1'b0;
        end else if (activity) begin
            cnt       <= '0;
            auto_stby <= 1'b0;
        end else if (cnt == CW'(IDLE_CYC - 1)) begin
            auto_stby <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R8
    stby_after_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(auto_stby) |-> !$past(activity));
endmodule

// File: rtl/mbfe_top.sv
// Asynchronous memory bus front end, top level.
// Filters the three strobes, delays address and data by the same latency,
// classifies the bus cycle, drives the data bus enables, reports writes and
// tracks idle time. Assumes DATA_W is even and the top data bit doubles as
// the byte select address bit in 8-bit organisation.
module mbfe_top
    import mbfe_pkg::*;
#(
    parameter int ADDR_W      = 22,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int CLK_PS      = 4000,
    parameter int GLITCH_PS   = 5000,
    parameter int IDLE_PS     = 300000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              x8_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] dq_in,
    output logic [1:0]        cyc_kind,
    output logic              dq_oe_lo,
    output logic              dq_oe_hi,
    output logic              wr_pulse,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_lsb,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_x8,
    output logic              auto_stby
);
    localparam int GLITCH_CYC = (GLITCH_PS + CLK_PS - 1) / CLK_PS;
    localparam int IDLE_CYC   = (IDLE_PS + CLK_PS - 1) / CLK_PS;
    localparam int LAT        = SYNC_STAGES + GLITCH_CYC;
    localparam int BUS_W      = 1 + ADDR_W + DATA_W;

    logic [2:0]        pins_raw, ctrl_f, ctrl_q;
    logic              ce_f, oe_f, we_f;
    logic [BUS_W-1:0]  bus_d;
    logic              byte_d;
    logic [ADDR_W-1:0] addr_d;
    logic [DATA_W-1:0] dq_d;
    logic [ADDR_W:0]   loc_now, loc_q;
    logic              activity;
    cyc_kind_t         kind;

    assign pins_raw = {ce_n, oe_n, we_n};

    // One filter per strobe pin.
    for (genvar i = 0; i < 3; i++) begin : g_strobe
        mbfe_deglitch #(
            .SYNC_STAGES (SYNC_STAGES),
            .HOLD_CYC    (GLITCH_CYC)
        ) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_in (pins_raw[i]),
            .level  (ctrl_f[i])
        );
    end

    assign ce_f = ctrl_f[2];
    assign oe_f = ctrl_f[1];
    assign we_f = ctrl_f[0];

    mbfe_delay #(
        .W     (BUS_W),
        .DEPTH (LAT)
    ) u_bus_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({x8_n, addr_in, dq_in}),
        .q     (bus_d)
    );

    assign byte_d = ~bus_d[BUS_W-1];
    assign addr_d = bus_d[DATA_W +: ADDR_W];
    assign dq_d   = bus_d[DATA_W-1:0];

    // Sort the filtered strobes into a cycle kind.
    always_comb begin
        if (ce_f)              kind = CYC_STANDBY;
        else if (!oe_f && we_f) kind = CYC_READ;
        else if (!we_f && oe_f) kind = CYC_WRITE;
        else                    kind = CYC_ODIS;
    end

    assign cyc_kind = kind;
    assign dq_oe_lo = (kind == CYC_READ);
    assign dq_oe_hi = (kind == CYC_READ) && !byte_d;

    mbfe_wrcap #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_wrcap (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_f     (ce_f),
        .oe_f     (oe_f),
        .we_f     (we_f),
        .byte_d   (byte_d),
        .addr_d   (addr_d),
        .dq_d     (dq_d),
        .wr_pulse (wr_pulse),
        .wr_addr  (wr_addr),
        .wr_lsb   (wr_lsb),
        .wr_data  (wr_data),
        .wr_x8    (wr_x8)
    );

    assign loc_now = {addr_d, byte_d & dq_d[DATA_W-1]};

    // Remember last strobe levels and location to detect bus activity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '1;
            loc_q  <= '0;
        end else begin
            ctrl_q <= ctrl_f;
            loc_q  <= loc_now;
        end
    end

    assign activity = (ctrl_f != ctrl_q) || (loc_now != loc_q);

    mbfe_idle #(
        .IDLE_CYC (IDLE_CYC)
    ) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .activity  (activity),
        .auto_stby (auto_stby)
    );

    // R2
    ce_high_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_f && $past(ce_f) && $past(ce_f, 2)) |-> !wr_pulse);

    // R7
    upper_needs_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_hi |-> dq_oe_lo);
endmodule

// File: tb/test_mbfe_top.sv
// Scoreboard bench for the asynchronous memory bus front end.
module test_mbfe_top;
    localparam int AW     = 22;
    localparam int DW     = 16;
    localparam int IDLE_N = 75;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, x8_n = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] dq_in = '0;
    logic [1:0]    cyc_kind;
    logic          dq_oe_lo, dq_oe_hi, wr_pulse, wr_lsb, wr_x8, auto_stby;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit prev_pulse = 0;
    logic [AW+DW+1:0] exp_q [$];

    always #2 clk = ~clk;

    mbfe_top #(
        .ADDR_W (AW),
        .DATA_W (DW)
    ) i_mbfe_top (
        .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .oe_n (oe_n), .we_n (we_n),
        .x8_n (x8_n), .addr_in (addr_in), .dq_in (dq_in), .cyc_kind (cyc_kind),
        .dq_oe_lo (dq_oe_lo), .dq_oe_hi (dq_oe_hi), .wr_pulse (wr_pulse),
        .wr_addr (wr_addr), .wr_lsb (wr_lsb), .wr_data (wr_data), .wr_x8 (wr_x8),
        .auto_stby (auto_stby)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop and compare each write report (R4 R5 R7 R10).
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_pulse) begin
                if (prev_pulse) chk(0, "R10 pulse longer than one cycle", 2, 1);
                if (exp_q.size() == 0) begin
                    chk(0, "R10 R2 R6 R9 unexpected write report", {wr_addr, wr_lsb, wr_data, wr_x8}, 0);
                end else begin
                    logic [AW+DW+1:0] e;
                    e = exp_q.pop_front();
                    chk({wr_addr, wr_lsb, wr_data, wr_x8} == e, "R4 R5 R7 R10 write fields",
                        {wr_addr, wr_lsb, wr_data, wr_x8}, e);
                end
            end
            prev_pulse = wr_pulse;
        end
    end

    // Driver: one write with chosen strobe orderings, pushing its expectation.
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input bit ce_first, input bit ce_rise_first,
                            input bit x8, input bit lsb);
        logic [DW-1:0] ed;
        ed = x8 ? {8'h00, d[7:0]} : d;
        exp_q.push_back({a, x8 & lsb, ed, x8});
        x8_n = ~x8; oe_n = 1'b1; addr_in = ~a; dq_in = 16'h5A5A;
        cyc(4);
        if (ce_first) ce_n = 1'b0; else we_n = 1'b0;
        cyc(4);
        addr_in = a; dq_in[15] = lsb;
        cyc(4);
        if (ce_first) we_n = 1'b0; else ce_n = 1'b0;
        cyc(6);
        chk(cyc_kind == 2'd2, "R1 write kind", cyc_kind, 2);
        addr_in = a ^ 22'h15555;
        dq_in = d;
        cyc(4);
        if (ce_rise_first) ce_n = 1'b1; else we_n = 1'b1;
        cyc(3);
        dq_in = ~d;
        cyc(3);
        ce_n = 1'b1; we_n = 1'b1;
        cyc(12);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R10 watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit saw_write;
        cyc(5);
        rst_n = 1'b1;
        cyc(1);
        // Reset state
        chk(cyc_kind == 2'd0, "R1 reset kind standby", cyc_kind, 0);
        chk({dq_oe_lo, dq_oe_hi, wr_pulse, auto_stby} == 4'b0, "R3 reset outputs low",
            {dq_oe_lo, dq_oe_hi, wr_pulse, auto_stby}, 0);

        // R1 R3 read in word mode
        ce_n = 1'b0; oe_n = 1'b0; cyc(10);
        chk(cyc_kind == 2'd1, "R1 read kind", cyc_kind, 1);
        chk({dq_oe_lo, dq_oe_hi} == 2'b11, "R3 word read enables", {dq_oe_lo, dq_oe_hi}, 3);
        oe_n = 1'b1; cyc(10);
        chk(cyc_kind == 2'd3, "R1 output disable kind", cyc_kind, 3);
        chk({dq_oe_lo, dq_oe_hi} == 2'b00, "R3 OE high enables off", {dq_oe_lo, dq_oe_hi}, 0);

        // R2 CE high: OE and WE ignored
        ce_n = 1'b1; cyc(8);
        oe_n = 1'b0; we_n = 1'b0; addr_in = 22'h0ABCD; cyc(10);
        chk(cyc_kind == 2'd0, "R2 CE high standby", cyc_kind, 0);
        chk({dq_oe_lo, dq_oe_hi} == 2'b00, "R2 CE high enables off", {dq_oe_lo, dq_oe_hi}, 0);
        we_n = 1'b1; oe_n = 1'b1; cyc(10);

        // R4 R5 all four strobe orderings, word mode
        do_write(22'h12345, 16'hBEEF, 1, 1, 0, 1);
        do_write(22'h2AAAA, 16'h1234, 1, 0, 0, 0);
        do_write(22'h05555, 16'hC3A1, 0, 1, 0, 1);
        do_write(22'h3FFFF, 16'h8001, 0, 0, 0, 0);
        // R7 byte mode, select bit both values
        do_write(22'h00F0F, 16'hFF7E, 1, 0, 1, 1);
        do_write(22'h10101, 16'h0081, 0, 1, 1, 0);
        x8_n = 1'b1;

        // R6 glitch on WE while CE low
        ce_n = 1'b0; cyc(8);
        saw_write = 0;
        we_n = 1'b0; cyc(1); we_n = 1'b1;
        for (int i = 0; i < 8; i++) begin cyc(1); if (cyc_kind == 2'd2) saw_write = 1; end
        chk(!saw_write, "R6 WE glitch rejected", saw_write, 0);
        // R6 glitch on CE while WE low
        ce_n = 1'b1; cyc(8);
        we_n = 1'b0; cyc(8);
        saw_write = 0;
        ce_n = 1'b0; cyc(1); ce_n = 1'b1;
        for (int i = 0; i < 8; i++) begin cyc(1); if (cyc_kind != 2'd0) saw_write = 1; end
        chk(!saw_write, "R6 CE glitch rejected", saw_write, 0);
        we_n = 1'b1; cyc(8);
        // R6 minimum accepted width
        addr_in = 22'h0C0DE; dq_in = 16'h7171;
        exp_q.push_back({22'h0C0DE, 1'b0, 16'h7171, 1'b0});
        ce_n = 1'b0; cyc(4);
        we_n = 1'b0; cyc(2); we_n = 1'b1;
        cyc(4); ce_n = 1'b1; cyc(12);

        // R9 OE low inside the write window
        addr_in = 22'h01111; dq_in = 16'h2222;
        ce_n = 1'b0; we_n = 1'b0; cyc(6);
        oe_n = 1'b0; cyc(5); oe_n = 1'b1; cyc(5);
        we_n = 1'b1; cyc(2); ce_n = 1'b1; cyc(12);
        chk(exp_q.size() == 0, "R9 R6 write reports matched so far", exp_q.size(), 0);

        // R8 automatic standby
        cyc(40);
        chk(auto_stby == 1'b0, "R8 not yet idle", auto_stby, 0);
        cyc(60);
        chk(auto_stby == 1'b1, "R8 idle flag set", auto_stby, 1);
        addr_in = 22'h02222; cyc(8);
        chk(auto_stby == 1'b0, "R8 activity clears flag", auto_stby, 0);
        ce_n = 1'b0; oe_n = 1'b0; cyc(IDLE_N + 25);
        chk(auto_stby == 1'b1, "R8 idle during long read", auto_stby, 1);
        chk(dq_oe_lo == 1'b1, "R8 read still drives in standby", dq_oe_lo, 1);

        // R7 byte-mode read enables
        x8_n = 1'b0; cyc(8);
        chk({dq_oe_lo, dq_oe_hi} == 2'b10, "R7 byte read enables", {dq_oe_lo, dq_oe_hi}, 2);
        ce_n = 1'b1; oe_n = 1'b1; x8_n = 1'b1; cyc(20);

        chk(exp_q.size() == 0, "R10 every write reported", exp_q.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule